// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

The block counts ticks from a slow, free-running timebase. When software does not restart it in time, it raises a system reset request. Software picks one of eight timeout lengths through a 3-bit select field and restarts the count by pulsing a kick input. When the timeout runs out, the block emits a one-cycle reset request and starts counting again from zero.

Turning the watchdog off takes a guarded step, so that a stray write cannot silence it. First a write sets a turn-off-enable bit, which opens a window of four clocks. Only a write made while that window is open can clear the enable bit. Hardware closes the window by itself. Setting the enable bit is always allowed. The register is 8 bits wide and uses this layout:

| Bits | Field |
|------|-------|
| 7..5 | reserved, always zero |
| 4 | turn-off-enable |
| 3 | enable |
| 2..0 | timeout select |

The tick input stands in for the timebase, which nominally runs at 1 MHz. The tick is assumed to be already synchronous to the clock.

Top module: `wdt_guard`

## Requirements
- R1: After reset, every register bit reads zero, the watchdog is off and rst_req is low.
- R2: Bits 7..5 of rd_data always read zero, whatever was written to them.
- R3: With enable (bit 3) at one and select value n in bits 2..0, rst_req rises one clock after the edge that samples the 2^(BASE_EXP+n)-th tick since the count last restarted. The count then restarts from zero, so the next request follows one full period later. Gaps between ticks do not change the count.
- R4: rst_req is high for exactly one clock per timeout.
- R5: A kick clears the count to zero. A kick in the same clock as a tick takes priority, and no reset request follows that clock.
- R6: While enable reads zero, ticks raise no reset request and the count is held at zero, so a later re-enable waits a full period.
- R7: A write with bit 4 at one sets the turn-off-enable bit. It reads one for the four clocks after that write and is then cleared by hardware. A write with bit 4 at zero leaves it unchanged.
- R8: A write clears enable only if turn-off-enable reads one before that write. This holds up to the fourth clock after the opening write. A single write that sets bit 4 and clears bit 3 while the window is closed leaves enable at one.
- R9: A write that tries to clear enable while the window is closed leaves enable at one, but it still updates the select bits.
- R10: If a new select value makes the period shorter than the count already reached, the next tick raises the reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Writes wr_data into the control register this clock |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register readback |
| kick | input | 1 | One-clock restart request |
| tick | input | 1 | One-clock timebase tick |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The hardest case to reach is the exact closing edge of the disable window. A clearing write on the fourth clock after the opening write must take effect, and the same write one clock later must be refused. The stimulus table drives both cases with an exact count of idle clocks after each opening write. It also drives the combined write that sets bit 4 and clears bit 3 together.

Directed runs shrink the timeout below a count already reached, to show that the next tick fires. They also land a kick on the same clock as a tick.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_EXP = 14,
  parameter int WIN_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       kick,
  input  logic       tick,
  output logic       rst_req
);
  localparam int CW = BASE_EXP + 8;
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [2:0]    psel;
  logic          en;
  logic [WW-1:0] win;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          toe;
  logic          expire;
  logic          unused_hi;

  assign unused_hi = ^wr_data[7:5];
  assign toe       = (win != '0);
  assign rd_data   = {3'b000, toe, en, psel};
  assign lim_m1    = (CW'(1) << (BASE_EXP + int'(psel))) - CW'(1);
  assign expire    = en & tick & ~kick & (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel    <= '0;
      en      <= 1'b0;
      win     <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      if (wr_en) begin
        psel <= wr_data[2:0];
        en   <= wr_data[3] | (en & ~toe);
      end
      if (wr_en && wr_data[4])
        win <= WW'(WIN_CYC);
      else if (toe)
        win <= win - 1'b1;
      if (!en || kick || expire)
        cnt <= '0;
      else if (tick)
        cnt <= cnt + 1'b1;
      rst_req <= expire;
    end
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_toe,
  input logic [7:0] rd_data,
  input logic       kick,
  input logic       rst_req
);
  // R2
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  kick_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rst_req);

  // R6
  fire_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rd_data[3]));

  // R7
  toe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_toe) |=> rd_data[4]);

  // R8
  guarded_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[3]) |-> $past(rd_data[4]));
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_toe(wr_data[4]),
  .rd_data(rd_data), .kick(kick), .rst_req(rst_req)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       kick = 1'b0;
  logic       tick = 1'b0;
  logic       rst_req;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_guard #(.BASE_EXP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .kick(kick), .tick(tick), .rst_req(rst_req)
  );

  // {write valid, write data, expected readback after the edge}
  localparam logic [16:0] VEC [0:20] = '{
    {1'b1, 8'h0D, 8'h0D}, {1'b1, 8'h02, 8'h0A}, {1'b1, 8'hE7, 8'h0F},
    {1'b1, 8'h18, 8'h18}, {1'b1, 8'h03, 8'h13}, {1'b0, 8'h00, 8'h13},
    {1'b0, 8'h00, 8'h13}, {1'b0, 8'h00, 8'h03}, {1'b1, 8'h18, 8'h18},
    {1'b0, 8'h00, 8'h18}, {1'b0, 8'h00, 8'h18}, {1'b0, 8'h00, 8'h18},
    {1'b1, 8'h00, 8'h00}, {1'b1, 8'h18, 8'h18}, {1'b0, 8'h00, 8'h18},
    {1'b0, 8'h00, 8'h18}, {1'b0, 8'h00, 8'h18}, {1'b0, 8'h00, 8'h08},
    {1'b1, 8'h00, 8'h08}, {1'b1, 8'h10, 8'h18}, {1'b1, 8'h00, 8'h10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic ticks_to_fire(input int maxn, input int gap, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      if (rst_req) begin
        n = i;
        break;
      end
      repeat (gap) step();
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    nbad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n;
    @(negedge clk);
    repeat (3) step();
    chk("R1 reset readback", rd_data, 8'h00);
    chk("R1 reset rst_req", rst_req, 0);
    rst_n = 1'b1;
    step();
    chk("R1 readback after release", rd_data, 8'h00);

    for (int i = 0; i < 21; i++) begin
      wr_en = VEC[i][16];
      wr_data = VEC[i][15:8];
      step();
      wr_en = 1'b0;
      wr_data = 8'h00;
      chk($sformatf("R2 R7 R8 R9 table step %0d", i), rd_data, VEC[i][7:0]);
    end
    repeat (6) step();

    ticks_to_fire(300, 0, n);
    chk("R6 no request while off", n, 0);

    wr(8'h08);
    ticks_to_fire(40, 0, n);
    chk("R3 select 0 period", n, 16);
    step();
    chk("R4 pulse width", rst_req, 0);
    ticks_to_fire(40, 0, n);
    chk("R3 restart after timeout", n, 16);
    ticks_to_fire(40, 2, n);
    chk("R3 sparse ticks", n, 16);

    wr(8'h0F);
    ticks_to_fire(3000, 0, n);
    chk("R3 select 7 period", n, 2048);
    wr(8'h0B);
    ticks_to_fire(300, 0, n);
    chk("R3 select 3 period", n, 128);

    ticks_to_fire(100, 0, n);
    chk("R5 no fire before kick", n, 0);
    kick = 1'b1;
    tick = 1'b1;
    step();
    kick = 1'b0;
    tick = 1'b0;
    chk("R5 kick with tick", rst_req, 0);
    ticks_to_fire(300, 0, n);
    chk("R5 full period after kick", n, 128);

    wr(8'h0F);
    ticks_to_fire(100, 0, n);
    chk("R10 long select no fire", n, 0);
    wr(8'h08);
    ticks_to_fire(5, 0, n);
    chk("R10 shrink fires on next tick", n, 1);

    ticks_to_fire(10, 0, n);
    chk("R6 partial count", n, 0);
    wr(8'h18);
    wr(8'h00);
    chk("R6 R8 disabled readback", rd_data[3], 0);
    repeat (8) step();
    wr(8'h08);
    ticks_to_fire(40, 0, n);
    chk("R6 re-enable full period", n, 16);

    finish_run();
  end
endmodule